// File: doc/BRIEF.md
# Floating-Point Register NaN-Boxing Unit

This unit sits between a 64-bit floating-point register file and the single-precision execution units. A 32-bit value kept in a 64-bit register is legal only when it is boxed, meaning its upper half is all ones. On the operand side, the compute path checks that box. A legal operand is forwarded. A malformed operand is replaced by the single-precision canonical NaN, and a flag reports the replacement.

On the result side, every 32-bit value headed for the register file is widened by filling the upper half with ones. A separate transfer mode serves loads, stores and integer moves. In that mode, outgoing 32-bit data is the low word of the register, taken without any inspection. Incoming 32-bit data is boxed the same way as a result.

In 64-bit handling every path is a plain pass-through. The outputs are either registered (one cycle of latency) or combinational, selected by a parameter.

Top module: `fp_nanbox_unit`

## Requirements
- R1: With `mode_i`=0 (compute) and `wide_i`=0 (32-bit), a register value whose bits 63:32 are all ones yields `opnd_o` = {32'hFFFFFFFF, bits 31:0 of the value} and `nan_sub_o`=0.
- R2: With `mode_i`=0 and `wide_i`=0, a register value with any zero in bits 63:32 yields `opnd_o` = 64'hFFFFFFFF_7FC00000 and `nan_sub_o`=1.
- R3: With `wide_i`=0, in either mode, `wb_o` = {32'hFFFFFFFF, `wr_val_i`[31:0]}; the upper half of `wr_val_i` has no effect.
- R4: With `mode_i`=1 (transfer) and `wide_i`=0, `opnd_o` = {32'h0, `rd_val_i`[31:0]} whatever the upper half holds, and `nan_sub_o`=0.
- R5: With `wide_i`=1, in either mode, `opnd_o` equals `rd_val_i`, `wb_o` equals `wr_val_i`, and `nan_sub_o`=0.
- R6: 64-bit values, including signalling NaNs and quiet NaNs with non-canonical payloads, pass through unchanged in both modes.
- R7: With `OUT_REG`=1 (default), the outputs reflect the inputs sampled at the previous rising clock edge. While `rst_n` is low, all outputs are zero.
- R8: `nan_sub_o` is never set outside 32-bit compute mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output stage |
| mode_i | input | 1 | 0 = compute, 1 = transfer |
| wide_i | input | 1 | 0 = 32-bit handling, 1 = 64-bit handling |
| rd_val_i | input | 64 | Value read from the register file (operand or outgoing transfer) |
| wr_val_i | input | 64 | Value to be written to the register file (result or incoming transfer) |
| opnd_o | output | 64 | Operand for execution, or outgoing transfer data |
| wb_o | output | 64 | Value to write into the register file |
| nan_sub_o | output | 1 | Canonical-NaN substitution occurred |

## Verification
The assertions assume that the inputs are stable and known at each rising edge, and that the output stage is enabled as in the default build. Under that assumption, each output pairs with the inputs captured one edge earlier. The bench drives the inputs only on falling edges and holds them through the following rising edge. It samples results shortly after that edge. The stimulus never leaves inputs undriven after reset is released.

// File: rtl/fpbox_pkg.sv
package fpbox_pkg;
    localparam int unsigned FLEN = 64;
    localparam int unsigned NLEN = 32;
    localparam int unsigned ULEN = FLEN - NLEN;
    localparam logic [NLEN-1:0] SP_CANON_NAN = 32'h7FC0_0000;

    typedef enum logic {
        MODE_COMPUTE = 1'b0,
        MODE_XFER    = 1'b1
    } fpbox_mode_e;

    typedef struct packed {
        logic [FLEN-1:0] opnd;
        logic [FLEN-1:0] wb;
        logic            subst;
    } fpbox_out_t;
endpackage

// File: rtl/fpbox_unbox.sv
module fpbox_unbox #(
    parameter int unsigned W_FULL = 64,
    parameter int unsigned W_NARROW = 32,
    parameter logic [W_NARROW-1:0] CANON = 32'h7FC0_0000
) (
    input  logic              xfer_i,
    input  logic              wide_i,
    input  logic [W_FULL-1:0] src_i,
    output logic [W_FULL-1:0] opnd_o,
    output logic              subst_o
);
    localparam int unsigned W_UP = W_FULL - W_NARROW;

    logic box_ok;

    always_comb begin
        box_ok  = &src_i[W_FULL-1:W_NARROW];
        subst_o = 1'b0;
        if (wide_i) begin
            opnd_o = src_i;
        end else if (xfer_i) begin
            opnd_o = {{W_UP{1'b0}}, src_i[W_NARROW-1:0]};
        end else if (box_ok) begin
            opnd_o = {{W_UP{1'b1}}, src_i[W_NARROW-1:0]};
        end else begin
            opnd_o  = {{W_UP{1'b1}}, CANON};
            subst_o = 1'b1;
        end
    end
endmodule

// File: rtl/fpbox_rebox.sv
module fpbox_rebox #(
    parameter int unsigned W_FULL = 64,
    parameter int unsigned W_NARROW = 32
) (
    input  logic              wide_i,
    input  logic [W_FULL-1:0] res_i,
    output logic [W_FULL-1:0] wb_o
);
    localparam int unsigned W_UP = W_FULL - W_NARROW;

    always_comb begin
        if (wide_i) wb_o = res_i;
        else        wb_o = {{W_UP{1'b1}}, res_i[W_NARROW-1:0]};
    end
endmodule

// File: rtl/fp_nanbox_unit.sv
module fp_nanbox_unit
    import fpbox_pkg::*;
#(
    parameter bit OUT_REG = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mode_i,
    input  logic            wide_i,
    input  logic [FLEN-1:0] rd_val_i,
    input  logic [FLEN-1:0] wr_val_i,
    output logic [FLEN-1:0] opnd_o,
    output logic [FLEN-1:0] wb_o,
    output logic            nan_sub_o
);
    fpbox_out_t      out_d, out_q;
    logic [FLEN-1:0] unbox_opnd, rebox_wb;
    logic            unbox_subst, is_xfer;

    assign is_xfer = (fpbox_mode_e'(mode_i) == MODE_XFER);

    fpbox_unbox #(.W_FULL(FLEN), .W_NARROW(NLEN), .CANON(SP_CANON_NAN)) u_unbox (
        .xfer_i (is_xfer),
        .wide_i (wide_i),
        .src_i  (rd_val_i),
        .opnd_o (unbox_opnd),
        .subst_o(unbox_subst)
    );

    fpbox_rebox #(.W_FULL(FLEN), .W_NARROW(NLEN)) u_rebox (
        .wide_i(wide_i),
        .res_i (wr_val_i),
        .wb_o  (rebox_wb)
    );

    always_comb begin
        out_d.opnd  = unbox_opnd;
        out_d.wb    = rebox_wb;
        out_d.subst = unbox_subst;
    end

    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (!rst_n) out_q <= '0;
                else        out_q <= out_d;
            end
        end else begin : g_comb
            assign out_q = out_d;
        end
    endgenerate

    assign opnd_o    = out_q.opnd;
    assign wb_o      = out_q.wb;
    assign nan_sub_o = out_q.subst;
endmodule

// File: rtl/fp_nanbox_unit_chk.sv
module fp_nanbox_unit_chk #(
    parameter bit OUT_REG = 1'b1
) (
    input logic        clk,
    input logic        rst_n,
    input logic        mode_i,
    input logic        wide_i,
    input logic [63:0] rd_val_i,
    input logic [63:0] wr_val_i,
    input logic [63:0] opnd_o,
    input logic [63:0] wb_o,
    input logic        nan_sub_o
);
    logic        c_mode, c_wide, c_ok;
    logic [63:0] c_rd, c_wr;

    generate
        if (OUT_REG) begin : g_dly
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    c_ok <= 1'b0; c_mode <= 1'b0; c_wide <= 1'b0;
                    c_rd <= '0;   c_wr <= '0;
                end else begin
                    c_ok <= 1'b1; c_mode <= mode_i; c_wide <= wide_i;
                    c_rd <= rd_val_i; c_wr <= wr_val_i;
                end
            end
        end else begin : g_now
            assign c_ok = 1'b1;
            assign c_mode = mode_i;
            assign c_wide = wide_i;
            assign c_rd = rd_val_i;
            assign c_wr = wr_val_i;
        end
    endgenerate

    assert_box_pass_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && !c_wide && !c_mode && (&c_rd[63:32])) |-> (opnd_o == c_rd && !nan_sub_o));
    assert_canon_sub_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && !c_wide && !c_mode && !(&c_rd[63:32])) |-> (opnd_o == 64'hFFFFFFFF_7FC00000 && nan_sub_o));
    assert_result_boxed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && !c_wide) |-> (wb_o[63:32] == 32'hFFFFFFFF && wb_o[31:0] == c_wr[31:0]));
    assert_xfer_trunc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && !c_wide && c_mode) |-> (opnd_o[63:32] == 32'h0 && opnd_o[31:0] == c_rd[31:0]));
    assert_wide_pass_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (c_ok && c_wide) |-> (opnd_o == c_rd && wb_o == c_wr));
    assert_flag_scope_R8: assert property (@(posedge clk) disable iff (!rst_n)
        nan_sub_o |-> (c_ok && !c_wide && !c_mode));
endmodule

bind fp_nanbox_unit fp_nanbox_unit_chk #(.OUT_REG(OUT_REG)) u_chk (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wide_i(wide_i),
    .rd_val_i(rd_val_i), .wr_val_i(wr_val_i),
    .opnd_o(opnd_o), .wb_o(wb_o), .nan_sub_o(nan_sub_o)
);

// File: tb/fp_nanbox_unit_tb_top.sv
module fp_nanbox_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode_i = 1'b0;
    logic        wide_i = 1'b0;
    logic [63:0] rd_val_i = '0;
    logic [63:0] wr_val_i = '0;
    logic [63:0] opnd_o, wb_o;
    logic        nan_sub_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [63:0] CANON_BOXED = 64'hFFFFFFFF_7FC00000;

    always #4 clk = ~clk;

    fp_nanbox_unit dut_i (
        .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .wide_i(wide_i),
        .rd_val_i(rd_val_i), .wr_val_i(wr_val_i),
        .opnd_o(opnd_o), .wb_o(wb_o), .nan_sub_o(nan_sub_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // drive on falling edge, result visible just after the next rising edge
    task automatic apply(input logic m, input logic w, input logic [63:0] rd, input logic [63:0] wr);
        @(negedge clk);
        mode_i = m; wide_i = w; rd_val_i = rd; wr_val_i = wr;
        @(posedge clk);
        #2;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        mode_i = 1'b1; wide_i = 1'b1; rd_val_i = '1; wr_val_i = '1;
        repeat (3) @(posedge clk);
        #2;
        check("R7 reset opnd", opnd_o, 64'h0);
        check("R7 reset wb", wb_o, 64'h0);
        check("R7 reset flag", {63'h0, nan_sub_o}, 64'h0);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_compute_valid();
        apply(1'b0, 1'b0, 64'hFFFFFFFF_3F800000, 64'h0);
        check("R1 opnd", opnd_o, 64'hFFFFFFFF_3F800000);
        check("R1 flag", {63'h0, nan_sub_o}, 64'h0);
        apply(1'b0, 1'b0, 64'hFFFFFFFF_7F800001, 64'h0);
        check("R1 snan kept", opnd_o, 64'hFFFFFFFF_7F800001);
    endtask

    task automatic t_compute_bad();
        logic [63:0] pats [3] = '{64'h00000000_3F800000, 64'hFFFFFFFE_12345678, 64'h7FFFFFFF_FFFFFFFF};
        for (int i = 0; i < 3; i++) begin
            apply(1'b0, 1'b0, pats[i], 64'h0);
            check("R2 opnd", opnd_o, CANON_BOXED);
            check("R2 flag", {63'h0, nan_sub_o}, 64'h1);
        end
    endtask

    task automatic t_result_box();
        apply(1'b0, 1'b0, 64'hFFFFFFFF_0, 64'h12345678_C0490FDB);
        check("R3 compute wb", wb_o, 64'hFFFFFFFF_C0490FDB);
        apply(1'b1, 1'b0, 64'h0, 64'h00000000_00000001);
        check("R3 xfer wb", wb_o, 64'hFFFFFFFF_00000001);
    endtask

    task automatic t_xfer_narrow();
        apply(1'b1, 1'b0, 64'h0BADF00D_DEADBEEF, 64'h0);
        check("R4 opnd", opnd_o, 64'h00000000_DEADBEEF);
        check("R4 flag", {63'h0, nan_sub_o}, 64'h0);
        apply(1'b1, 1'b0, 64'hFFFFFFFF_7FC00001, 64'h0);
        check("R4 boxed src", opnd_o, 64'h00000000_7FC00001);
    endtask

    task automatic t_wide();
        for (int m = 0; m < 2; m++) begin
            apply(m[0], 1'b1, 64'h400921FB_54442D18, 64'h00000000_12345678);
            check("R5 opnd", opnd_o, 64'h400921FB_54442D18);
            check("R5 wb", wb_o, 64'h00000000_12345678);
            check("R8 flag", {63'h0, nan_sub_o}, 64'h0);
        end
    endtask

    task automatic t_payload();
        for (int m = 0; m < 2; m++) begin
            apply(m[0], 1'b1, 64'h7FF00000_0000ABCD, 64'hFFF80000_00C0FFEE);
            check("R6 snan opnd", opnd_o, 64'h7FF00000_0000ABCD);
            check("R6 qnan wb", wb_o, 64'hFFF80000_00C0FFEE);
        end
    endtask

    task automatic t_latency();
        apply(1'b0, 1'b1, 64'h1111, 64'h2222);
        @(negedge clk);
        mode_i = 1'b0; wide_i = 1'b0; rd_val_i = 64'h0; wr_val_i = 64'h0;
        #1;
        check("R7 held opnd", opnd_o, 64'h1111);
        check("R7 held flag", {63'h0, nan_sub_o}, 64'h0);
        @(posedge clk);
        #2;
        check("R7 updated opnd", opnd_o, CANON_BOXED);
    endtask

    initial begin
        t_reset();
        t_compute_valid();
        t_compute_bad();
        t_result_box();
        t_xfer_narrow();
        t_wide();
        t_payload();
        t_latency();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule